// File: doc/BRIEF.md
# DDR Self-Refresh Entry and Exit Sequencer

This block takes a DDR SDRAM into self refresh and brings it back out. A power manager asks for entry and exit with single-cycle request pulses. The block first issues the refresh command with the clock enable pulled low, then holds the enable low for the whole low-power stay. When exit is requested, it runs the recovery sequence that the memory needs before normal commands may resume. All banks must already be idle when entry is requested.

The exit sequence has four phases, each with a fixed length. First the block waits until the clock-stable input has been high for `CLK_WAIT` consecutive cycles. Then it raises the clock enable and issues only NOPs for `TXSNR` cycles. Next it issues one mode-register load that resets the DLL. Finally it issues NOPs for `DLL_LOCK` cycles (200 by default). Only after that does it report ready again. The device's DLL switches off on its own during self refresh, so no read may be issued before this point.

The command pins are driven from the sequencer state with no extra pipeline stage. Each output changes one clock after the request or counter event that causes it.

Top module: `ddr_srx_seq`

## Requirements
- R1: While reset is asserted and right after it is released, the outputs are: `ready`=1, `in_sr`=0, `cke`=1, command NOP (`cs_n`,`ras_n`,`cas_n`,`we_n` = 0,1,1,1), and `ba` and `addr` all zero.
- R2: An entry request sampled while ready produces, on the next cycle, exactly one cycle with `cke`=0 and the refresh encoding (`cs_n`,`ras_n`,`cas_n`,`we_n` = 0,0,0,1). `ready` goes to 0 in that same cycle.
- R3: From the cycle after the refresh command until the clock enable is raised, `cke` stays 0 and `in_sr` stays 1.
- R4: After an exit request, `cke` stays low until `clk_stable` has been sampled high on `CLK_WAIT` consecutive cycles. A low sample restarts the count.
- R5: For the `TXSNR` cycles after `cke` rises, the command is NOP, `ready` is 0 and `in_sr` is 0.
- R6: After those cycles there is exactly one cycle with the load-mode encoding (0,0,0,0), `ba`=00, address bit 8 set to 1 and every other address bit 0.
- R7: After the DLL-reset command, NOPs are issued for `DLL_LOCK` cycles. `ready` returns to 1 in the cycle after the last of them.
- R8: An exit request that arrives during the refresh-command cycle is remembered. The exit sequence starts as soon as the low-power hold is reached, with no second request needed.
- R9: An exit request while ready has no effect. An entry request during the exit sequence also has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sr_enter_req | input | 1 | Pulse: enter self refresh |
| sr_exit_req | input | 1 | Pulse: leave self refresh |
| clk_stable | input | 1 | Memory clock is running and stable |
| cke | output | 1 | Clock enable to the memory |
| cs_n | output | 1 | Chip select, active low |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| ba | output | BA_W | Bank address |
| addr | output | A_W | Address bus |
| in_sr | output | 1 | Memory is held in self refresh |
| ready | output | 1 | Normal commands may be issued |

## Verification
The bench goes after the following corner cases:
- **Clock-stable glitch.** A drop in `clk_stable` partway through the stable wait must restart the count. A design that only paused the count would raise `cke` early.
- **Exit during the refresh cycle.** An exit pulse landing in the refresh-command cycle must be kept. A design that dropped it would stay in self refresh for good.
- **Stray requests.** An entry pulse during the NOP phases and an exit pulse while ready must both be ignored. A design that obeyed them would break the recovery sequence or issue a refresh with `cke` high.
- **Phase lengths.** The length of every phase is compared cycle by cycle against a behavioural model. An off-by-one in the tXSNR or DLL wait counts shows up as a `ready` edge one cycle early or late.

// File: rtl/ddr_srx_pkg.sv
package ddr_srx_pkg;

  typedef enum logic [2:0] {
    ST_IDLE     = 3'd0,
    ST_ENTER    = 3'd1,
    ST_IN_SR    = 3'd2,
    ST_WAIT_CLK = 3'd3,
    ST_XSNR     = 3'd4,
    ST_DLL_RST  = 3'd5,
    ST_DLL_WAIT = 3'd6,
    ST_READY    = 3'd7
  } srx_state_e;

  typedef struct packed {
    logic cs_n;
    logic ras_n;
    logic cas_n;
    logic we_n;
  } dram_cmd_t;

  localparam dram_cmd_t CMD_NOP  = '{cs_n: 1'b0, ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1};
  localparam dram_cmd_t CMD_AREF = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b0, we_n: 1'b1};
  localparam dram_cmd_t CMD_LMR  = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b0, we_n: 1'b0};

endpackage

// File: rtl/srx_timer.sv
module srx_timer #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          inc,
  output logic [CW-1:0] cnt
);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (clr)      cnt_d = '0;
    else if (inc) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign cnt = cnt_q;

endmodule

// File: rtl/srx_ctrl.sv
module srx_ctrl
  import ddr_srx_pkg::*;
#(
  parameter int CLK_WAIT = 4,
  parameter int TXSNR    = 12,
  parameter int DLL_LOCK = 200,
  parameter int CW       = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          enter_req,
  input  logic          exit_req,
  input  logic          clk_stable,
  input  logic [CW-1:0] cnt,
  output srx_state_e    state,
  output logic          cnt_clr,
  output logic          cnt_inc
);

  localparam logic [CW-1:0] CLK_LAST  = CW'(CLK_WAIT - 1);
  localparam logic [CW-1:0] XSNR_LAST = CW'(TXSNR - 1);
  localparam logic [CW-1:0] DLL_LAST  = CW'(DLL_LOCK - 1);

  srx_state_e state_q, state_d;
  logic       pend_q, pend_d;

  always_comb begin
    state_d = state_q;
    pend_d  = pend_q;
    unique case (state_q)
      ST_IDLE, ST_READY: if (enter_req) state_d = ST_ENTER;
      ST_ENTER: begin
        state_d = ST_IN_SR;
        if (exit_req) pend_d = 1'b1;
      end
      ST_IN_SR: if (exit_req || pend_q) begin
        state_d = ST_WAIT_CLK;
        pend_d  = 1'b0;
      end
      ST_WAIT_CLK: if (clk_stable && cnt == CLK_LAST) state_d = ST_XSNR;
      ST_XSNR:     if (cnt == XSNR_LAST) state_d = ST_DLL_RST;
      ST_DLL_RST:  state_d = ST_DLL_WAIT;
      ST_DLL_WAIT: if (cnt == DLL_LAST) state_d = ST_READY;
      default:     state_d = ST_IDLE;
    endcase
  end

  always_comb begin
    cnt_clr = (state_d != state_q) || (state_q == ST_WAIT_CLK && !clk_stable);
    cnt_inc = !cnt_clr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      pend_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      pend_q  <= pend_d;
    end
  end

  assign state = state_q;

  // R7: the DLL lock wait never runs past its length
  assert_dll_wait_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_DLL_WAIT) |-> (cnt <= DLL_LAST));

  // R4: the stable wait is only left on a stable-clock sample
  assert_exit_needs_stable_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_WAIT_CLK && state_d == ST_XSNR) |-> clk_stable);

  // R8: a request remembered from the entry cycle is used once the hold is reached
  assert_pending_exit_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IN_SR && pend_q) |=> (state_q == ST_WAIT_CLK));

endmodule

// File: rtl/srx_cmd_drv.sv
module srx_cmd_drv
  import ddr_srx_pkg::*;
#(
  parameter int BA_W    = 2,
  parameter int A_W     = 13,
  parameter int DLL_BIT = 8
) (
  input  srx_state_e      state,
  output logic            cke,
  output dram_cmd_t       cmd,
  output logic [BA_W-1:0] ba,
  output logic [A_W-1:0]  addr,
  output logic            in_sr,
  output logic            ready
);

  always_comb begin
    cke   = 1'b1;
    cmd   = CMD_NOP;
    ba    = '0;
    addr  = '0;
    in_sr = 1'b0;
    ready = 1'b0;
    unique case (state)
      ST_IDLE, ST_READY: ready = 1'b1;
      ST_ENTER: begin
        cke = 1'b0;
        cmd = CMD_AREF;
      end
      ST_IN_SR, ST_WAIT_CLK: begin
        cke   = 1'b0;
        in_sr = 1'b1;
      end
      ST_DLL_RST: begin
        cmd           = CMD_LMR;
        addr[DLL_BIT] = 1'b1;
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/ddr_srx_seq.sv
module ddr_srx_seq
  import ddr_srx_pkg::*;
#(
  parameter int CLK_WAIT = 4,
  parameter int TXSNR    = 12,
  parameter int DLL_LOCK = 200,
  parameter int BA_W     = 2,
  parameter int A_W      = 13
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            sr_enter_req,
  input  logic            sr_exit_req,
  input  logic            clk_stable,
  output logic            cke,
  output logic            cs_n,
  output logic            ras_n,
  output logic            cas_n,
  output logic            we_n,
  output logic [BA_W-1:0] ba,
  output logic [A_W-1:0]  addr,
  output logic            in_sr,
  output logic            ready
);

  localparam int MAX_A  = (CLK_WAIT > TXSNR) ? CLK_WAIT : TXSNR;
  localparam int MAX_T  = (MAX_A > DLL_LOCK) ? MAX_A : DLL_LOCK;
  localparam int CW     = $clog2(MAX_T + 1);

  srx_state_e    state;
  logic          cnt_clr, cnt_inc;
  logic [CW-1:0] cnt;
  dram_cmd_t     cmd;

  srx_ctrl #(
    .CLK_WAIT(CLK_WAIT), .TXSNR(TXSNR), .DLL_LOCK(DLL_LOCK), .CW(CW)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n), .enter_req(sr_enter_req), .exit_req(sr_exit_req),
    .clk_stable(clk_stable), .cnt(cnt), .state(state),
    .cnt_clr(cnt_clr), .cnt_inc(cnt_inc)
  );

  srx_timer #(.CW(CW)) u_timer (
    .clk(clk), .rst_n(rst_n), .clr(cnt_clr), .inc(cnt_inc), .cnt(cnt)
  );

  srx_cmd_drv #(.BA_W(BA_W), .A_W(A_W), .DLL_BIT(8)) u_drv (
    .state(state), .cke(cke), .cmd(cmd), .ba(ba), .addr(addr),
    .in_sr(in_sr), .ready(ready)
  );

  assign cs_n  = cmd.cs_n;
  assign ras_n = cmd.ras_n;
  assign cas_n = cmd.cas_n;
  assign we_n  = cmd.we_n;

  // R2: the clock enable only falls together with the refresh encoding
  assert_entry_is_refresh_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cke) |-> (!cs_n && !ras_n && !cas_n && we_n));

  // R3: while held in self refresh the clock enable stays low
  assert_cke_low_in_sr_R3: assert property (@(posedge clk) disable iff (!rst_n)
    in_sr |-> !cke);

  // R4: the clock enable only rises after a stable-clock sample
  assert_rise_after_stable_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cke) |-> $past(clk_stable));

  // R5: the first cycle with the enable back high carries a NOP
  assert_nop_on_rise_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cke) |-> (!cs_n && ras_n && cas_n && we_n && !ready));

  // R7: ready never comes back straight after the DLL-reset command
  assert_no_early_ready_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!ras_n && !we_n) |=> !ready);

endmodule

// File: tb/ddr_srx_seq_bench.sv
`timescale 1ns/1ps
module ddr_srx_seq_bench;

  localparam int CLK_WAIT = 4;
  localparam int TXSNR    = 12;
  localparam int DLL_LOCK = 200;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic enter = 1'b0, leave = 1'b0, stable = 1'b0;
  logic cke, cs_n, ras_n, cas_n, we_n, in_sr, ready;
  logic [1:0]  ba;
  logic [12:0] addr;

  int vectors = 0;
  int errors  = 0;
  int cycles  = 0;
  string force_tag = "";

  always #2.5 clk = ~clk;

  ddr_srx_seq #(.CLK_WAIT(CLK_WAIT), .TXSNR(TXSNR), .DLL_LOCK(DLL_LOCK)) u_ddr_srx_seq (
    .clk(clk), .rst_n(rst_n), .sr_enter_req(enter), .sr_exit_req(leave),
    .clk_stable(stable), .cke(cke), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n),
    .we_n(we_n), .ba(ba), .addr(addr), .in_sr(in_sr), .ready(ready)
  );

  // Reference model: phase number and cycles spent in it.
  // 0 ready, 1 refresh cycle, 2 hold, 3 stable wait, 4 tXSNR, 5 DLL reset, 6 DLL wait
  int  ph = 0;
  int  n  = 0;
  bit  remembered = 0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph = 0; n = 0; remembered = 0;
    end else begin
      case (ph)
        0: if (enter) begin ph = 1; n = 0; end
        1: begin remembered = leave; ph = 2; n = 0; end
        2: if (leave || remembered) begin ph = 3; n = 0; remembered = 0; end
        3: begin
          if (!stable) n = 0;
          else begin n++; if (n == CLK_WAIT) begin ph = 4; n = 0; end end
        end
        4: begin n++; if (n == TXSNR) begin ph = 5; n = 0; end end
        5: begin ph = 6; n = 0; end
        default: begin n++; if (n == DLL_LOCK) begin ph = 0; n = 0; end end
      endcase
    end
  end

  task automatic check(string tag, string what, int act, int exp);
    vectors++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d at cycle %0d", tag, what, act, exp, cycles);
    end
  endtask

  always @(negedge clk) begin
    string tag;
    int    e_cke, e_cmd, e_addr, e_sr, e_rdy;
    cycles++;
    if (rst_n) begin
      case (ph)
        0: tag = "R7"; 1: tag = "R2"; 2: tag = "R3"; 3: tag = "R4";
        4: tag = "R5"; 5: tag = "R6"; default: tag = "R7";
      endcase
      if (force_tag != "") tag = force_tag;
      e_cke  = (ph >= 1 && ph <= 3) ? 0 : 1;
      e_cmd  = (ph == 1) ? 4'b0001 : (ph == 5) ? 4'b0000 : 4'b0111;
      e_addr = (ph == 5) ? 256 : 0;
      e_sr   = (ph == 2 || ph == 3) ? 1 : 0;
      e_rdy  = (ph == 0) ? 1 : 0;
      check(tag, "cke", int'(cke), e_cke);
      check(tag, "in_sr", int'(in_sr), e_sr);
      check(tag, "ready", int'(ready), e_rdy);
      if (!e_sr) begin
        check(tag, "cmd", int'({cs_n, ras_n, cas_n, we_n}), e_cmd);
        check(tag, "addr", int'(addr), e_addr);
        check(tag, "ba", int'(ba), 0);
      end
    end
  end

  task automatic step(int k);
    for (int i = 0; i < k; i++) @(negedge clk);
  endtask

  task automatic pulse_enter();
    enter = 1'b1; step(1); enter = 1'b0;
  endtask

  task automatic pulse_exit();
    leave = 1'b1; step(1); leave = 1'b0;
  endtask

  initial begin
    // R1: outputs during and right after reset
    step(2);
    check("R1", "cke in reset", int'(cke), 1);
    check("R1", "ready in reset", int'(ready), 1);
    check("R1", "in_sr in reset", int'(in_sr), 0);
    check("R1", "cmd in reset", int'({cs_n, ras_n, cas_n, we_n}), 4'b0111);
    check("R1", "addr in reset", int'(addr), 0);
    rst_n = 1'b1;
    force_tag = "R1"; step(3); force_tag = "";

    // R9: exit request while ready is ignored
    force_tag = "R9"; pulse_exit(); step(3); force_tag = "";

    // R2/R3/R4: normal entry, hold, stable wait with a glitch
    pulse_enter(); step(6);
    pulse_exit(); step(2);
    stable = 1'b1; step(2); stable = 1'b0; step(1); stable = 1'b1;
    step(CLK_WAIT + 3);
    // R9: entry request during the tXSNR phase is ignored
    force_tag = "R9"; pulse_enter(); step(2); force_tag = "";
    step(TXSNR + DLL_LOCK + 10);

    // R8: exit pulse during the refresh cycle is remembered
    stable = 1'b0;
    pulse_enter();
    force_tag = "R8"; pulse_exit(); step(4); force_tag = "";
    stable = 1'b1;
    step(CLK_WAIT + TXSNR + DLL_LOCK + 10);

    // Long hold, clock comes back late
    stable = 1'b0;
    pulse_enter(); step(10);
    pulse_exit(); step(6); stable = 1'b1;
    step(CLK_WAIT + TXSNR + DLL_LOCK + 10);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    #20000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

endmodule